// File: doc/BRIEF.md
# Encoder Position Counter with Hold

This block keeps a 16-bit signed-free position count for an incremental encoder front end. A decoder outside the block turns quadrature signals into single-cycle up and down strobes; while the run control is high the counter steps by one per strobe. When the run control drops, a hold-select input chooses what happens to the count. With hold-select low the counter is parked at all-ones and reads back as zero, and the next start loads a preset value. With hold-select high the count freezes, reads back as the frozen value, and the next start continues from it.

A small synchronous write port sets the preset value and two compare values and clears the sticky underflow flag. The block raises single-cycle pulses when a down step wraps the count from zero to all-ones, when the count takes a value equal to either compare value, and when a valid edge arrives on the clear input. The clear edge polarity is selectable, and a valid edge zeroes the count while running.

Top module: `enc_pos_counter`

## Requirements
- R1: During and right after reset (run control low, hold-select low) the read port shows 0x0000, the underflow flag is 0 and every interrupt output is 0.
- R2: While run control is low and hold-select is low, the read port shows 0x0000 and strobes have no effect; the internal count is parked at 0xFFFF.
- R3: On a cycle where run control rises with hold-select low, the count becomes the preset value (written at address 0), overriding any strobe in that cycle.
- R4: While run control is low and hold-select is high, the count and the read port keep their value and ignore strobes; a later start continues from that value without loading the preset.
- R5: While running, an up strobe alone adds one, a down strobe alone subtracts one, and both together leave the count unchanged; an up step from 0xFFFF wraps to 0x0000.
- R6: A down step from 0x0000 to 0xFFFF raises the underflow interrupt for exactly one cycle and sets the sticky underflow flag; the up wrap does neither.
- R7: Writing a 1 to bit 0 at address 3 clears the underflow flag; an underflow in the same cycle wins and leaves the flag set.
- R8: When the count is updated to a value equal to compare value 0 (address 1) or compare value 1 (address 2), the matching interrupt pulses for one cycle; no pulse when the count does not change.
- R9: With edge-select 0 a rising edge of the clear input is valid, with edge-select 1 a falling edge; a valid edge pulses the clear interrupt for one cycle and, while running, sets the count to 0x0000; while stopped the count is not touched.
- R10: In one cycle the preset load on start takes priority over a clear edge, which takes priority over strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | Run control; high counts |
| hold_sel | input | 1 | Stop behaviour: 1 freeze, 0 park and reload |
| step_up | input | 1 | Up count strobe |
| step_dn | input | 1 | Down count strobe |
| clr_in | input | 1 | Encoder clear input |
| clr_edge_sel | input | 1 | 0 rising edge valid, 1 falling edge valid |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 preset, 1 compare 0, 2 compare 1, 3 status clear |
| wr_data | input | 16 | Write data |
| count_rd | output | 16 | Count read port |
| uf_flag | output | 1 | Sticky underflow flag |
| irq_uf | output | 1 | Underflow pulse |
| irq_cmp0 | output | 1 | Compare 0 match pulse |
| irq_cmp1 | output | 1 | Compare 1 match pulse |
| irq_clr | output | 1 | Valid clear edge pulse |

## Verification
The assertions take the strobes, run control and clear input as already synchronous to the clock, so an edge on the clear input is seen for exactly one cycle and a strobe is a level for one cycle. They also assume compare and preset values may change at any edge, which is why match checks compare against the previous cycle's value. The stimulus drives every input on the falling edge, keeps the clear input low through reset so no spurious edge is seen, and only toggles one control at a time except where a priority case is being exercised on purpose.

// File: rtl/epc_pkg.sv
// Package: shared constants and register addresses for the encoder
// position counter. Assumes a two-bit write address space.
package epc_pkg;
    localparam int NUM_CMP = 2;

    typedef enum logic [1:0] {
        ADDR_PRESET = 2'd0,
        ADDR_CMP0   = 2'd1,
        ADDR_CMP1   = 2'd2,
        ADDR_STATUS = 2'd3
    } epc_addr_e;

    localparam int STAT_UF_BIT = 0;
endpackage

// File: rtl/epc_regs.sv
// Module: write-only configuration registers (preset and compare values)
// plus decode of the write-one-to-clear status access. Assumes writes are
// single-cycle strobes synchronous to clk.
module epc_regs
    import epc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [1:0]                   wr_addr,
    input  logic [W-1:0]                 wr_data,
    output logic [W-1:0]                 preset,
    output logic [NUM_CMP-1:0][W-1:0]    cmp_val,
    output logic                         uf_clr
);
    // Preset register, loaded by writes to its address.
    always_ff @(posedge clk) begin
        if (!rst_n)
            preset <= '0;
        else if (wr_en && wr_addr == ADDR_PRESET)
            preset <= wr_data;
    end

    // One compare register per channel, at consecutive addresses.
    for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
        localparam logic [1:0] MY_ADDR = 2'(int'(ADDR_CMP0) + i);
        always_ff @(posedge clk) begin
            if (!rst_n)
                cmp_val[i] <= '0;
            else if (wr_en && wr_addr == MY_ADDR)
                cmp_val[i] <= wr_data;
        end
    end

    // Status clear request: a one written to the underflow bit.
    always_comb uf_clr = wr_en && (wr_addr == ADDR_STATUS) && wr_data[STAT_UF_BIT];
endmodule

// File: rtl/epc_edge.sv
// Module: valid-edge detector for the encoder clear input with selectable
// polarity. Assumes clr_in is already synchronous; the input is held low
// during reset so no edge is reported right after it.
module epc_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_in,
    input  logic edge_sel,
    output logic hit
);
    logic clr_q;

    // Remember the previous sample of the clear input.
    always_ff @(posedge clk) begin
        if (!rst_n) clr_q <= 1'b0;
        else        clr_q <= clr_in;
    end

    // Rising edge when edge_sel is 0, falling edge when it is 1.
    always_comb hit = edge_sel ? (clr_q && !clr_in) : (!clr_q && clr_in);

    p_edge_needs_change_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (clr_in != clr_q));
endmodule

// File: rtl/epc_core.sv
// Module: the up/down position counter, stop/hold behaviour, read mux and
// underflow flag. Assumes strobes are one-cycle levels synchronous to clk.
// Priority while running: preset load on start, then clear, then strobes.
module epc_core #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_en,
    input  logic         hold_sel,
    input  logic         step_up,
    input  logic         step_dn,
    input  logic         clr_hit,
    input  logic [W-1:0] preset,
    input  logic         uf_clr,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] cnt_d,
    output logic         cnt_upd,
    output logic [W-1:0] count_rd,
    output logic         uf_flag,
    output logic         irq_uf
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic run_q;
    logic reload, clr_ld, inc, dec, uf_set;

    // Decode this cycle's action by priority.
    always_comb begin
        reload = run_en && !run_q && !hold_sel;
        clr_ld = run_en && !reload && clr_hit;
        inc    = run_en && !reload && !clr_hit && step_up && !step_dn;
        dec    = run_en && !reload && !clr_hit && step_dn && !step_up;
        uf_set = dec && (cnt_q == '0);
        cnt_upd = reload || clr_ld || inc || dec;
    end

    // Next count value.
    always_comb begin
        if (!run_en)    cnt_d = hold_sel ? cnt_q : '1;
        else if (reload) cnt_d = preset;
        else if (clr_ld) cnt_d = '0;
        else if (inc)    cnt_d = cnt_q + ONE;
        else if (dec)    cnt_d = cnt_q - ONE;
        else             cnt_d = cnt_q;
    end

    // Count, run history, underflow pulse and sticky flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '1;
            run_q   <= 1'b0;
            irq_uf  <= 1'b0;
            uf_flag <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            run_q  <= run_en;
            irq_uf <= uf_set;
            if (uf_set)      uf_flag <= 1'b1;
            else if (uf_clr) uf_flag <= 1'b0;
        end
    end

    // Read port: zero while parked, otherwise the counter.
    always_comb count_rd = (run_en || hold_sel) ? cnt_q : '0;

    p_park_all_ones_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !hold_sel) |=> (cnt_q == '1));
    p_reload_preset_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !run_q && !hold_sel) |=> (cnt_q == $past(preset)));
    p_hold_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && hold_sel) |=> $stable(cnt_q));
    p_step_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && run_q && !clr_hit && step_up && !step_dn) |=> (cnt_q == $past(cnt_q) + ONE));
    p_cancel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && run_q && !clr_hit && step_up && step_dn) |=> $stable(cnt_q));
    p_uf_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_uf |-> (uf_flag && cnt_q == '1 && $past(cnt_q) == '0));
    p_uf_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_uf |=> !irq_uf);
    p_uf_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (uf_clr && !uf_set) |=> !uf_flag);
    p_clear_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_hit && run_en && run_q) |=> (cnt_q == '0));
endmodule

// File: rtl/epc_match.sv
// Module: compare-match pulse generators, one per compare register. A pulse
// is raised in the cycle the counter takes a value equal to the compare
// value, and only when the count was actually updated.
module epc_match
    import epc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [W-1:0]              cnt_d,
    input  logic [W-1:0]              cnt_q,
    input  logic                      cnt_upd,
    input  logic [NUM_CMP-1:0][W-1:0] cmp_val,
    output logic [NUM_CMP-1:0]        irq_cmp
);
    for (genvar i = 0; i < NUM_CMP; i++) begin : g_ch
        // Register a match on an updating cycle.
        always_ff @(posedge clk) begin
            if (!rst_n) irq_cmp[i] <= 1'b0;
            else        irq_cmp[i] <= cnt_upd && (cnt_d == cmp_val[i]);
        end

        p_match_value_r8: assert property (@(posedge clk) disable iff (!rst_n)
            irq_cmp[i] |-> (cnt_q == $past(cmp_val[i])));
    end
endmodule

// File: rtl/enc_pos_counter.sv
// Module: top of the encoder position counter. Wires the register port,
// clear-edge detector, counter core and compare-match logic together.
module enc_pos_counter
    import epc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_en,
    input  logic         hold_sel,
    input  logic         step_up,
    input  logic         step_dn,
    input  logic         clr_in,
    input  logic         clr_edge_sel,
    input  logic         wr_en,
    input  logic [1:0]   wr_addr,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] count_rd,
    output logic         uf_flag,
    output logic         irq_uf,
    output logic         irq_cmp0,
    output logic         irq_cmp1,
    output logic         irq_clr
);
    logic [W-1:0]              preset;
    logic [NUM_CMP-1:0][W-1:0] cmp_val;
    logic                      uf_clr, clr_hit, cnt_upd;
    logic [W-1:0]              cnt_q, cnt_d;
    logic [NUM_CMP-1:0]        irq_cmp;

    epc_regs #(.W(W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .preset(preset), .cmp_val(cmp_val), .uf_clr(uf_clr)
    );

    epc_edge u_edge (
        .clk(clk), .rst_n(rst_n), .clr_in(clr_in), .edge_sel(clr_edge_sel), .hit(clr_hit)
    );

    epc_core #(.W(W)) u_core (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .hold_sel(hold_sel),
        .step_up(step_up), .step_dn(step_dn), .clr_hit(clr_hit), .preset(preset),
        .uf_clr(uf_clr), .cnt_q(cnt_q), .cnt_d(cnt_d), .cnt_upd(cnt_upd),
        .count_rd(count_rd), .uf_flag(uf_flag), .irq_uf(irq_uf)
    );

    epc_match #(.W(W)) u_match (
        .clk(clk), .rst_n(rst_n), .cnt_d(cnt_d), .cnt_q(cnt_q), .cnt_upd(cnt_upd),
        .cmp_val(cmp_val), .irq_cmp(irq_cmp)
    );

    // Valid clear edge pulse, registered alongside the count.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_clr <= 1'b0;
        else        irq_clr <= clr_hit;
    end

    always_comb begin
        irq_cmp0 = irq_cmp[0];
        irq_cmp1 = irq_cmp[1];
    end

    p_clr_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_clr |=> !irq_clr);
    p_rd_zero_parked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !hold_sel) |-> (count_rd == '0));
endmodule

// File: tb/enc_pos_counter_test.sv
`timescale 1ns/1ps
module enc_pos_counter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 0, hold_sel = 0, step_up = 0, step_dn = 0;
    logic        clr_in = 0, clr_edge_sel = 0, wr_en = 0;
    logic [1:0]  wr_addr = 0;
    logic [15:0] wr_data = 0;
    logic [15:0] count_rd;
    logic        uf_flag, irq_uf, irq_cmp0, irq_cmp1, irq_clr;
    int checks = 0, fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    enc_pos_counter uut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .hold_sel(hold_sel),
        .step_up(step_up), .step_dn(step_dn), .clr_in(clr_in),
        .clr_edge_sel(clr_edge_sel), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .count_rd(count_rd), .uf_flag(uf_flag),
        .irq_uf(irq_uf), .irq_cmp0(irq_cmp0), .irq_cmp1(irq_cmp1), .irq_clr(irq_clr)
    );

    // {run, hold, up, dn, read, irq_uf, uf_flag, cmp0, cmp1}; preset 2, cmp0 1, cmp1 FFFE
    localparam logic [23:0] VEC [0:14] = '{
        {4'b1000, 16'h0002, 4'b0000},
        {4'b1001, 16'h0001, 4'b0010},
        {4'b1001, 16'h0000, 4'b0000},
        {4'b1001, 16'hFFFF, 4'b1100},
        {4'b1001, 16'hFFFE, 4'b0101},
        {4'b1011, 16'hFFFE, 4'b0100},
        {4'b1010, 16'hFFFF, 4'b0100},
        {4'b1010, 16'h0000, 4'b0100},
        {4'b1010, 16'h0001, 4'b0110},
        {4'b0110, 16'h0001, 4'b0100},
        {4'b0101, 16'h0001, 4'b0100},
        {4'b1101, 16'h0000, 4'b0100},
        {4'b0000, 16'h0000, 4'b0100},
        {4'b0010, 16'h0000, 4'b0100},
        {4'b1000, 16'h0002, 4'b0100}
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 0;
    endtask

    task automatic drive(input logic r, input logic h, input logic u, input logic d);
        run_en = r; hold_sel = h; step_up = u; step_dn = d;
    endtask

    initial begin
        #100000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog all requirements actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        tick(); tick();
        // R1: reset state
        chk("R1 read in reset", count_rd, 16'h0000);
        chk("R1 flag in reset", uf_flag, 0);
        chk("R1 irqs in reset", {irq_uf, irq_cmp0, irq_cmp1, irq_clr}, 0);
        rst_n = 1;
        tick();
        chk("R1 read after reset", count_rd, 16'h0000);
        wr(2'd0, 16'h0002);
        wr(2'd1, 16'h0001);
        wr(2'd2, 16'hFFFE);
        chk("R2 parked read", count_rd, 16'h0000);

        // Table walk: R2 R3 R4 R5 R6 R8
        for (int i = 0; i < 15; i++) begin
            drive(VEC[i][23], VEC[i][22], VEC[i][21], VEC[i][20]);
            tick();
            chk($sformatf("R3/R4/R5 read step %0d", i), count_rd, VEC[i][19:4]);
            chk($sformatf("R6 irq_uf step %0d", i), irq_uf, VEC[i][3]);
            chk($sformatf("R6 uf_flag step %0d", i), uf_flag, VEC[i][2]);
            chk($sformatf("R8 cmp0 step %0d", i), irq_cmp0, VEC[i][1]);
            chk($sformatf("R8 cmp1 step %0d", i), irq_cmp1, VEC[i][0]);
        end
        drive(1, 0, 0, 0);

        // R7: write-one-to-clear
        wr(2'd3, 16'h0001);
        chk("R7 flag cleared", uf_flag, 0);
        drive(1, 0, 0, 1); tick(); tick();
        chk("R5 down to zero", count_rd, 16'h0000);
        wr_en = 1; wr_addr = 2'd3; wr_data = 16'h0001;
        tick();
        wr_en = 0; drive(1, 0, 0, 0);
        chk("R7 set wins read", count_rd, 16'hFFFF);
        chk("R7 set wins flag", uf_flag, 1);
        chk("R6 irq on underflow", irq_uf, 1);

        // R9: rising edge valid with select 0
        clr_in = 1; tick();
        chk("R9 rising clears", count_rd, 16'h0000);
        chk("R9 rising irq", irq_clr, 1);
        tick();
        chk("R9 irq one cycle", irq_clr, 0);
        clr_in = 0; tick();
        chk("R9 falling ignored sel0", irq_clr, 0);
        clr_edge_sel = 1; drive(1, 0, 1, 0); tick();
        chk("R5 up after clear", count_rd, 16'h0001);
        drive(1, 0, 0, 0); clr_in = 1; tick();
        chk("R9 rising ignored sel1 irq", irq_clr, 0);
        chk("R9 rising ignored sel1 read", count_rd, 16'h0001);
        clr_in = 0; tick();
        chk("R9 falling clears", count_rd, 16'h0000);
        chk("R9 falling irq", irq_clr, 1);
        clr_in = 1; drive(1, 0, 1, 0); tick();
        chk("R5 up to one", count_rd, 16'h0001);
        drive(0, 1, 0, 0); clr_in = 0; tick();
        chk("R9 stopped irq", irq_clr, 1);
        chk("R9 stopped keeps count", count_rd, 16'h0001);

        // R10: reload beats clear and strobe
        drive(0, 0, 0, 0); clr_in = 1; tick();
        chk("R2 parked again", count_rd, 16'h0000);
        drive(1, 0, 1, 0); clr_in = 0; tick();
        chk("R10 reload wins read", count_rd, 16'h0002);
        chk("R10 clear irq still", irq_clr, 1);
        drive(1, 0, 0, 0); tick();

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule